// File: doc/BRIEF.md
# YCbCr to RGB Pixel Converter

This block turns a stream of 8-bit full-range luma/chroma pixels into 8-bit red, green and blue pixels. Each accepted pixel first has the mid-scale offset taken off both chroma samples, which makes them signed. The pixel is then multiplied through a fixed colour matrix whose coefficients are integers scaled by 2^14. The block adds half an output step, shifts the fraction away and limits each channel to 0..255.

Pixels enter and leave through a valid/ready handshake. The pipeline has three register stages: chroma centring, coefficient multiply, and sum/round/clamp. When the consumer holds ready low, the whole pipeline freezes and no pixel is lost, duplicated or reordered. The asynchronous active-low reset is released inside the block through a two-flop synchroniser, and the block does not accept pixels before that release.

Top module: `ycc2rgb_pipe`

## Requirements
- R1: A pixel with Cb = Cr = 128 gives R = G = B = Y for every Y in 0..255.
- R2: With dcb = Cb-128 and dcr = Cr-128, red is clamp(floor((16384*Y + 22970*dcr + 8192) / 16384)).
- R3: Green is clamp(floor((16384*Y - 5638*dcb - 11700*dcr + 8192) / 16384)).
- R4: Blue is clamp(floor((16384*Y + 29032*dcb + 8192) / 16384)).
- R5: Results are rounded to nearest with halves going up, not truncated. For example, Y=0, Cb=128, Cr=130 gives R=3 and Cr=129 gives R=1.
- R6: Any channel whose rounded value is below 0 is output as 0.
- R7: Any channel whose rounded value is above 255 is output as 255.
- R8: When ready stays high, a pixel accepted at a rising edge appears with out_valid high right after the third rising edge counted from that edge. The pipeline empties three edges after the last acceptance.
- R9: After reset release, in_ready equals (out_ready or not out_valid). While out_valid is high and out_ready is low, out_valid and all three colour outputs hold. Every pixel leaves exactly once and in arrival order.
- R10: While rst_n is low, out_valid and in_ready are low. in_ready stays low until the second rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma, 128 is neutral |
| in_cr | input | 8 | Red-difference chroma, 128 is neutral |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
A pixel accepted at a rising edge is due on the outputs after the third enabled edge. Each cycle that out_ready is low while out_valid is high adds one edge of delay, and during the two edges of reset synchronisation the block accepts nothing. The bench carries its own three-slot pipeline of expected colours. At every falling edge it compares out_valid, the three channels and in_ready with that model, then advances the model by the same ready rule the requirements state. Directed grey, rounding and saturation pixels run first, then random streams with an always-ready consumer and with a randomly stalling one.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  // Rounded integer value of num/den scaled by 2^frac.
  function automatic int scale_coef(input longint num, input longint den, input int frac);
    longint scaled;
    scaled = (num * (longint'(1) << frac) + den / 2) / den;
    return int'(scaled);
  endfunction

endpackage

// File: rtl/ycc_center_stage.sv
module ycc_center_stage #(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_y,
  input  logic [PIX_W-1:0]        in_cb,
  input  logic [PIX_W-1:0]        in_cr,
  output logic                    v_q,
  output logic [PIX_W-1:0]        y_q,
  output logic signed [PIX_W:0]   dcb_q,
  output logic signed [PIX_W:0]   dcr_q
);

  localparam logic signed [PIX_W:0] MID = (PIX_W+1)'(1 << (PIX_W - 1));

  logic                  v_d;
  logic [PIX_W-1:0]      y_d;
  logic signed [PIX_W:0] dcb_d;
  logic signed [PIX_W:0] dcr_d;

  always_comb begin
    v_d   = v_q;
    y_d   = y_q;
    dcb_d = dcb_q;
    dcr_d = dcr_q;
    if (en) begin
      v_d   = in_valid;
      y_d   = in_y;
      dcb_d = $signed({1'b0, in_cb}) - MID;
      dcr_d = $signed({1'b0, in_cr}) - MID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      y_q   <= '0;
      dcb_q <= '0;
      dcr_q <= '0;
    end else begin
      v_q   <= v_d;
      y_q   <= y_d;
      dcb_q <= dcb_d;
      dcr_q <= dcr_d;
    end
  end

endmodule

// File: rtl/ycc_product_stage.sv
module ycc_product_stage #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int PROD_W = 25,
  parameter int K_RCR  = 22970,
  parameter int K_GCB  = 5638,
  parameter int K_GCR  = 11700,
  parameter int K_BCB  = 29032
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     v_in,
  input  logic [PIX_W-1:0]         y_in,
  input  logic signed [PIX_W:0]    dcb_in,
  input  logic signed [PIX_W:0]    dcr_in,
  output logic                     v_q,
  output logic [PIX_W-1:0]         y_q,
  output logic signed [PROD_W-1:0] p_rcr_q,
  output logic signed [PROD_W-1:0] p_gcb_q,
  output logic signed [PROD_W-1:0] p_gcr_q,
  output logic signed [PROD_W-1:0] p_bcb_q
);

  localparam logic signed [COEF_W-1:0] C_RCR = COEF_W'(K_RCR);
  localparam logic signed [COEF_W-1:0] C_GCB = COEF_W'(K_GCB);
  localparam logic signed [COEF_W-1:0] C_GCR = COEF_W'(K_GCR);
  localparam logic signed [COEF_W-1:0] C_BCB = COEF_W'(K_BCB);

  logic                     v_d;
  logic [PIX_W-1:0]         y_d;
  logic signed [PROD_W-1:0] p_rcr_d, p_gcb_d, p_gcr_d, p_bcb_d;

  always_comb begin
    v_d     = v_q;
    y_d     = y_q;
    p_rcr_d = p_rcr_q;
    p_gcb_d = p_gcb_q;
    p_gcr_d = p_gcr_q;
    p_bcb_d = p_bcb_q;
    if (en) begin
      v_d     = v_in;
      y_d     = y_in;
      p_rcr_d = PROD_W'(C_RCR) * PROD_W'(dcr_in);
      p_gcb_d = PROD_W'(C_GCB) * PROD_W'(dcb_in);
      p_gcr_d = PROD_W'(C_GCR) * PROD_W'(dcr_in);
      p_bcb_d = PROD_W'(C_BCB) * PROD_W'(dcb_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      y_q     <= '0;
      p_rcr_q <= '0;
      p_gcb_q <= '0;
      p_gcr_q <= '0;
      p_bcb_q <= '0;
    end else begin
      v_q     <= v_d;
      y_q     <= y_d;
      p_rcr_q <= p_rcr_d;
      p_gcb_q <= p_gcb_d;
      p_gcr_q <= p_gcr_d;
      p_bcb_q <= p_bcb_d;
    end
  end

endmodule

// File: rtl/ycc_round_clamp.sv
module ycc_round_clamp #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14,
  parameter int ACC_W  = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic [PIX_W-1:0]        pix_q
);

  localparam logic signed [ACC_W-1:0] TOP = ACC_W'((longint'(1) << PIX_W) - 1);

  logic signed [ACC_W-1:0] whole;
  logic [PIX_W-1:0]        pix_d;

  always_comb begin
    whole = acc_in >>> FRAC_W;
    pix_d = pix_q;
    if (en) begin
      if (whole[ACC_W-1]) begin
        pix_d = '0;
      end else if (whole > TOP) begin
        pix_d = '1;
      end else begin
        pix_d = whole[PIX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
    end else begin
      pix_q <= pix_d;
    end
  end

endmodule

// File: rtl/ycc2rgb_pipe.sv
module ycc2rgb_pipe
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_cr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);

  localparam int COEF_W = FRAC_W + 2;
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 2;
  localparam int NCH    = 3;
  localparam int K_RCR  = scale_coef(1402, 1000, FRAC_W);
  localparam int K_GCB  = scale_coef(34414, 100000, FRAC_W);
  localparam int K_GCR  = scale_coef(71414, 100000, FRAC_W);
  localparam int K_BCB  = scale_coef(1772, 1000, FRAC_W);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(longint'(1) << (FRAC_W - 1));

  // Reset release synchroniser
  logic [1:0] sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign core_rst_n = sync_q[1];

  // Pipeline-wide advance enable
  logic en;
  logic v3_q, v3_d;

  always_comb begin
    en       = core_rst_n && (out_ready || !v3_q);
    in_ready = en;
  end

  // Stage 1: chroma centring
  logic                  v1_q;
  logic [PIX_W-1:0]      y1_q;
  logic signed [PIX_W:0] dcb1_q, dcr1_q;

  ycc_center_stage #(.PIX_W(PIX_W)) u_center (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .en       (en),
    .in_valid (in_valid),
    .in_y     (in_y),
    .in_cb    (in_cb),
    .in_cr    (in_cr),
    .v_q      (v1_q),
    .y_q      (y1_q),
    .dcb_q    (dcb1_q),
    .dcr_q    (dcr1_q)
  );

  // Stage 2: coefficient products
  logic                     v2_q;
  logic [PIX_W-1:0]         y2_q;
  logic signed [PROD_W-1:0] p_rcr, p_gcb, p_gcr, p_bcb;

  ycc_product_stage #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .PROD_W (PROD_W),
    .K_RCR  (K_RCR),
    .K_GCB  (K_GCB),
    .K_GCR  (K_GCR),
    .K_BCB  (K_BCB)
  ) u_product (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .en      (en),
    .v_in    (v1_q),
    .y_in    (y1_q),
    .dcb_in  (dcb1_q),
    .dcr_in  (dcr1_q),
    .v_q     (v2_q),
    .y_q     (y2_q),
    .p_rcr_q (p_rcr),
    .p_gcb_q (p_gcb),
    .p_gcr_q (p_gcr),
    .p_bcb_q (p_bcb)
  );

  // Stage 3: channel sums, then round and clamp per channel
  logic signed [ACC_W-1:0] y_term;
  logic signed [ACC_W-1:0] acc [NCH];
  logic [PIX_W-1:0]        pix [NCH];

  always_comb begin
    y_term = $signed({{(ACC_W-PIX_W-FRAC_W){1'b0}}, y2_q, {FRAC_W{1'b0}}});
    acc[0] = y_term + ACC_W'(p_rcr) + HALF;
    acc[1] = y_term - ACC_W'(p_gcb) - ACC_W'(p_gcr) + HALF;
    acc[2] = y_term + ACC_W'(p_bcb) + HALF;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    ycc_round_clamp #(
      .PIX_W  (PIX_W),
      .FRAC_W (FRAC_W),
      .ACC_W  (ACC_W)
    ) u_clamp (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .en     (en),
      .acc_in (acc[ch]),
      .pix_q  (pix[ch])
    );
  end

  always_comb begin
    v3_d = en ? v2_q : v3_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      v3_q <= 1'b0;
    end else begin
      v3_q <= v3_d;
    end
  end

  assign out_valid = v3_q;
  assign out_r     = pix[0];
  assign out_g     = pix[1];
  assign out_b     = pix[2];

endmodule

// File: rtl/ycc2rgb_pipe_chk.sv
module ycc2rgb_pipe_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);

  always @(posedge clk) begin
    if (!rst_n) begin
      // R10
      reset_idle_chk: assert (!out_valid && !in_ready);
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R8
  latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) ##1 (!(in_valid && in_ready) && out_ready)
      ##1 (!(in_valid && in_ready) && out_ready) |=> !out_valid);

endmodule

bind ycc2rgb_pipe ycc2rgb_pipe_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b)
);

// File: tb/ycc2rgb_pipe_bench.sv
module ycc2rgb_pipe_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int WDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_r, out_g, out_b;

  ycc2rgb_pipe u_ycc2rgb_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_y      (in_y),
    .in_cb     (in_cb),
    .in_cr     (in_cr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  bit    stall_mode = 1'b0;
  string phase = "R10";

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_pix(input int y, input int cb, input int cr, input int ch);
    int dcb, dcr, acc, q;
    dcb = cb - 128;
    dcr = cr - 128;
    case (ch)
      0:       acc = y * 16384 + 22970 * dcr + 8192;
      1:       acc = y * 16384 - 5638 * dcb - 11700 * dcr + 8192;
      default: acc = y * 16384 + 29032 * dcb + 8192;
    endcase
    q = acc >>> 14;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic string tag_for(input int ch);
    if (phase == "R1" || phase == "R5" || phase == "R6" || phase == "R7") return phase;
    case (ch)
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  // Behavioural model: three slots of expected pixels plus reset sync state
  bit mv[3];
  int mr[3], mg[3], mb[3];
  bit ms0 = 1'b0, ms1 = 1'b0;

  always @(negedge clk) begin : model_step
    bit en;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mv[i] = 1'b0;
      ms0 = 1'b0;
      ms1 = 1'b0;
    end else if (!finished) begin
      check(out_valid === mv[2], (phase == "R9") ? "R9" : "R8", "out_valid",
            int'(out_valid), int'(mv[2]));
      if (mv[2] && out_valid) begin
        check(int'(out_r) == mr[2], tag_for(0), "out_r", int'(out_r), mr[2]);
        check(int'(out_g) == mg[2], tag_for(1), "out_g", int'(out_g), mg[2]);
        check(int'(out_b) == mb[2], tag_for(2), "out_b", int'(out_b), mb[2]);
      end
      en = ms1 && (out_ready || !mv[2]);
      check(in_ready === en, ms1 ? "R9" : "R10", "in_ready", int'(in_ready), int'(en));
      if (en) begin
        for (int i = 2; i > 0; i--) begin
          mv[i] = mv[i-1];
          mr[i] = mr[i-1];
          mg[i] = mg[i-1];
          mb[i] = mb[i-1];
        end
        mv[0] = in_valid;
        mr[0] = ref_pix(in_y, in_cb, in_cr, 0);
        mg[0] = ref_pix(in_y, in_cb, in_cr, 1);
        mb[0] = ref_pix(in_y, in_cb, in_cr, 2);
      end
      ms1 = ms0;
      ms0 = 1'b1;
    end
  end

  // Consumer: always ready, or randomly stalling
  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // Called at one time unit after a rising edge; returns at the same point.
  task automatic push(input int y, input int cb, input int cr);
    in_valid = 1'b1;
    in_y     = 8'(y);
    in_cb    = 8'(cb);
    in_cr    = 8'(cr);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: idle while reset is held
    check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b0, "R10", "in_ready in reset", int'(in_ready), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready after sync", int'(in_ready), 1);
    @(posedge clk);
    #1;

    // R1: grey pixels
    phase = "R1";
    for (int y = 0; y < 256; y += 15) push(y, 128, 128);
    push(255, 128, 128);
    idle(6);

    // R5: rounding to nearest
    phase = "R5";
    push(0, 128, 130);
    push(0, 128, 129);
    push(100, 127, 131);
    push(7, 129, 126);
    idle(6);

    // R6: low saturation
    phase = "R6";
    push(0, 128, 0);
    push(0, 255, 255);
    push(0, 0, 128);
    push(10, 0, 0);
    idle(6);

    // R7: high saturation
    phase = "R7";
    push(255, 255, 255);
    push(255, 0, 0);
    push(250, 128, 255);
    idle(6);

    // R2 R3 R4: random pixels, consumer always ready
    phase = "R2";
    for (int i = 0; i < 300; i++) begin
      push(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(6);

    // R9: random pixels under a randomly stalling consumer
    phase = "R9";
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      push(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)));
    end
    stall_mode = 1'b0;
    idle(10);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL R9 watchdog expired: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule